// File: doc/BRIEF.md
# Command-List DMA Register Writer

This block is a bus-master engine that walks a command list held in memory and turns it into register writes. Each group of the list opens with a 32-bit header holding four 8-bit slot codes, consumed least significant byte first. Each slot names one target register and is followed by one 32-bit data word. The low seven bits of a slot code pick a word-aligned register, and the top bit steers the write to the mirrored copy of the register block, which also launches the blitter.

A write to one particular register moves the engine into a secondary list. Writes to the register just before it set the secondary start. The secondary list is walked either as another register-write list or as a raw image-load stream, in which every word goes straight to the blitter load port. When the secondary list is used up, the engine resumes the primary list with a fresh header, or stops if the primary is also used up. A per-window word budget caps how many memory reads the engine makes between two window grants.

Software loads the primary start pointer and then the primary end pointer while the engine is idle. The end-pointer load starts the walk. A one-cycle pulse reports that the list is finished.

Top module: `cmdlist_dma`

## Requirements
- R1: After reset the engine is idle (`eng_state` = 0, where 0 = idle, 1 = primary, 2 = secondary), with `mem_req`, `reg_wr_valid`, `img_valid` and `list_done` all low.
- R2: Pointer loads act only while idle. `ld_sel` = 0 loads the primary start and `ld_sel` = 1 loads the primary end and starts the primary walk. A load during a walk changes nothing. Bits [1:0] of a pointer are a mode field that reads and comparisons ignore.
- R3: When no header is held, the engine reads a header word at the current address and advances the address by 4. It then reads one data word per slot at consecutive word addresses. After four slots it reads a new header.
- R4: Each data word produces one register write. `reg_wr_offset` is the slot code bits [6:0] times 4, `reg_wr_mirror` is slot code bit 7, and `reg_wr_data` is the word. The write appears one cycle after the read completes.
- R5: A slot code of 0x15 that comes up while the address is at or past the end pointer causes no read and no write. The slot is consumed and the end check follows.
- R6: A list finishes when its address is greater than or equal to its end pointer. This is checked after every data word, and before any header read, so a start at or past the end makes no read. Finishing the primary list gives a single-cycle `list_done` pulse and returns to idle.
- R7: In the primary list, a write to slot index 0x30 loads the secondary start pointer. A write to index 0x31 loads the secondary end pointer and switches to the secondary list, dropping any remaining slots of the primary header. The switch takes precedence over the primary reaching its end in the same word.
- R8: With secondary start bit 0 clear, the secondary list is decoded as a register-write list exactly as in R3 and R4.
- R9: With secondary start bit 0 set, every secondary word is sent to `img_data` with `img_valid`, one cycle after its read, with no header decoding.
- R10: When the secondary list finishes, the engine returns to the primary list and reads a fresh header there. If the primary address is already at or past its end, the engine instead pulses `list_done` and goes idle.
- R11: At most 280 reads (headers and data together) complete between two `win_start` pulses. A `win_start` pulse lets a stalled walk continue.
- R12: Once raised, `mem_req` and `mem_addr` hold steady until a cycle with `mem_rsp_valid` high completes the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_start | input | 1 | Window grant; refills the read budget |
| ld_valid | input | 1 | Pointer load strobe |
| ld_sel | input | 1 | 0 = primary start, 1 = primary end (starts walk) |
| ld_data | input | 32 | Pointer value, mode in bits [1:0] |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rsp_valid | input | 1 | Completes the pending read this cycle |
| mem_rsp_data | input | 32 | Read data |
| reg_wr_valid | output | 1 | Register write strobe |
| reg_wr_offset | output | 9 | Register byte offset |
| reg_wr_mirror | output | 1 | Write targets the blitter-start mirror |
| reg_wr_data | output | 32 | Register write data |
| img_valid | output | 1 | Image-load word strobe |
| img_data | output | 32 | Image-load word |
| list_done | output | 1 | One-cycle end-of-list pulse |
| eng_state | output | 2 | 0 idle, 1 primary, 2 secondary |

## Verification
Two functions can fall in the same cycle: the data word that switches to the secondary list can also be the word that brings the primary address to its end. The image-load case sets this up by placing the secondary-end write as the last primary word. The bench judges the outcome from what follows: the secondary image words must still stream out, followed by exactly one `list_done`. The secondary end and the primary-already-done condition likewise coincide there, and must end in idle rather than a fresh primary header read.

// File: rtl/cld_pkg.sv
`timescale 1ns/1ps
package cld_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_PRI  = 2'd1,
    ENG_SEC  = 2'd2
  } eng_state_e;

  localparam int PTR_W = 32;

  // Byte address part of a pointer: the mode bits are cleared.
  function automatic logic [PTR_W-1:0] ptr_addr(input logic [PTR_W-1:0] p);
    return {p[PTR_W-1:2], 2'b00};
  endfunction

  // Register byte offset named by a slot code.
  function automatic logic [8:0] slot_offset(input logic [7:0] code);
    return {code[6:0], 2'b00};
  endfunction

  // A list is used up once its address part reaches or passes the end.
  function automatic logic reached(input logic [PTR_W-1:0] a, input logic [PTR_W-1:0] e);
    return ptr_addr(a) >= ptr_addr(e);
  endfunction
endpackage

// File: rtl/cld_budget.sv
`timescale 1ns/1ps
module cld_budget #(
  parameter int BUDGET = 280
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_start,
  input  logic word_done,
  output logic exhausted
);
  localparam int CW = $clog2(BUDGET + 1);
  localparam logic [CW-1:0] LIMIT = CW'(BUDGET);

  logic [CW-1:0] used;

  always_ff @(posedge clk) begin
    if (!rst_n)         used <= '0;
    else if (win_start) used <= word_done ? CW'(1) : '0;
    else if (word_done) used <= used + CW'(1);
  end

  assign exhausted = (used >= LIMIT);

  a_r11_never_over: assert property (@(posedge clk) disable iff (!rst_n)
    used <= LIMIT);
  a_r11_no_word_when_spent: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |-> !word_done);
endmodule

// File: rtl/cld_slots.sv
`timescale 1ns/1ps
module cld_slots (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        hdr_load,
  input  logic [31:0] hdr_word,
  input  logic        slot_step,
  output logic [7:0]  cur_code,
  output logic        hdr_due
);
  logic [31:0] hdr;
  logic [1:0]  grp;
  logic        loaded;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr    <= '0;
      grp    <= '0;
      loaded <= 1'b0;
    end else if (clear) begin
      grp    <= '0;
      loaded <= 1'b0;
    end else if (hdr_load) begin
      hdr    <= hdr_word;
      grp    <= '0;
      loaded <= 1'b1;
    end else if (slot_step) begin
      hdr <= {8'h00, hdr[31:8]};
      grp <= grp + 2'd1;
      if (grp == 2'd3) loaded <= 1'b0;
    end
  end

  assign cur_code = hdr[7:0];
  assign hdr_due  = !loaded;

  a_r3_step_needs_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    slot_step |-> loaded);
  a_r3_no_double_load: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_load |-> !slot_step);
endmodule

// File: rtl/cld_ptrs.sv
`timescale 1ns/1ps
module cld_ptrs #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_pa,
  input  logic          ld_pe,
  input  logic [PW-1:0] ld_data,
  input  logic          pa_adv,
  input  logic          sa_adv,
  input  logic          sa_set,
  input  logic          se_set,
  input  logic [PW-1:0] set_data,
  output logic [PW-1:0] pa,
  output logic [PW-1:0] pe,
  output logic [PW-1:0] sa,
  output logic [PW-1:0] se
);
  localparam logic [PW-1:0] STEP = PW'(4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa <= '0;
      pe <= '0;
      sa <= '0;
      se <= '0;
    end else begin
      if (ld_pa)       pa <= ld_data;
      else if (pa_adv) pa <= pa + STEP;
      if (ld_pe)       pe <= ld_data;
      if (sa_set)      sa <= set_data;
      else if (sa_adv) sa <= sa + STEP;
      if (se_set)      se <= set_data;
    end
  end

  a_r2_load_not_during_walk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_pa && pa_adv));
endmodule

// File: rtl/cmdlist_dma.sv
`timescale 1ns/1ps
module cmdlist_dma #(
  parameter int         BUDGET       = 280,
  parameter logic [7:0] PAD_CODE     = 8'h15,
  parameter logic [6:0] SEC_ADDR_IDX = 7'h30,
  parameter logic [6:0] SEC_END_IDX  = 7'h31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        win_start,
  input  logic        ld_valid,
  input  logic        ld_sel,
  input  logic [31:0] ld_data,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        reg_wr_valid,
  output logic [8:0]  reg_wr_offset,
  output logic        reg_wr_mirror,
  output logic [31:0] reg_wr_data,
  output logic        img_valid,
  output logic [31:0] img_data,
  output logic        list_done,
  output logic [1:0]  eng_state
);
  import cld_pkg::*;

  eng_state_e  state, nxt;
  logic [31:0] pa, pe, sa, se, cur_addr, cur_end, word_addr;
  logic [7:0]  cur_code;
  logic        busy, hdr_due, exhausted, img_mode, at_end, idle_exit, pad_skip;
  logic        rd_need, xfer, is_hdr, is_data, is_img, slot_step;
  logic        sw_sec, set_sa, end_after, word_end, done_now, clr, ld_pa, ld_pe;

  assign busy      = (state != ENG_IDLE);
  assign ld_pa     = ld_valid && !busy && !ld_sel;
  assign ld_pe     = ld_valid && !busy && ld_sel;
  assign cur_addr  = (state == ENG_SEC) ? sa : pa;
  assign cur_end   = (state == ENG_SEC) ? se : pe;
  assign img_mode  = (state == ENG_SEC) && sa[0];
  assign word_addr = ptr_addr(cur_addr);
  assign at_end    = reached(cur_addr, cur_end);

  // Finish without reading: a header or image word would lie past the end.
  assign idle_exit = busy && at_end && (hdr_due || img_mode);
  assign pad_skip  = busy && !img_mode && !hdr_due && at_end && (cur_code == PAD_CODE);
  assign rd_need   = busy && !idle_exit && !pad_skip;
  assign mem_req   = rd_need && !exhausted;
  assign mem_addr  = word_addr;
  assign xfer      = mem_req && mem_rsp_valid;

  assign is_hdr    = xfer && !img_mode && hdr_due;
  assign is_data   = xfer && !img_mode && !hdr_due;
  assign is_img    = xfer && img_mode;
  assign slot_step = is_data || pad_skip;

  assign set_sa    = is_data && (state == ENG_PRI) && (cur_code[6:0] == SEC_ADDR_IDX);
  assign sw_sec    = is_data && (state == ENG_PRI) && (cur_code[6:0] == SEC_END_IDX);

  assign end_after = pad_skip ? 1'b1 : reached(word_addr + 32'd4, cur_end);
  assign word_end  = (is_data || is_img || pad_skip) && end_after;

  always_comb begin
    nxt      = state;
    done_now = 1'b0;
    unique case (state)
      ENG_IDLE: if (ld_pe) nxt = ENG_PRI;
      ENG_PRI: begin
        if (idle_exit) begin
          nxt      = ENG_IDLE;
          done_now = 1'b1;
        end else if (sw_sec) begin
          nxt = ENG_SEC;
        end else if (word_end) begin
          nxt      = ENG_IDLE;
          done_now = 1'b1;
        end
      end
      ENG_SEC: begin
        if (idle_exit || word_end) begin
          if (reached(pa, pe)) begin
            nxt      = ENG_IDLE;
            done_now = 1'b1;
          end else begin
            nxt = ENG_PRI;
          end
        end
      end
      default: nxt = ENG_IDLE;
    endcase
  end

  assign clr = (nxt != state);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ENG_IDLE;
    else        state <= nxt;
  end

  cld_ptrs #(.PW(32)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_pa    (ld_pa),
    .ld_pe    (ld_pe),
    .ld_data  (ld_data),
    .pa_adv   (xfer && (state == ENG_PRI)),
    .sa_adv   (xfer && (state == ENG_SEC)),
    .sa_set   (set_sa),
    .se_set   (sw_sec),
    .set_data (mem_rsp_data),
    .pa       (pa),
    .pe       (pe),
    .sa       (sa),
    .se       (se)
  );

  cld_slots u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clr),
    .hdr_load  (is_hdr),
    .hdr_word  (mem_rsp_data),
    .slot_step (slot_step),
    .cur_code  (cur_code),
    .hdr_due   (hdr_due)
  );

  cld_budget #(.BUDGET(BUDGET)) u_budget (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_start (win_start),
    .word_done (xfer),
    .exhausted (exhausted)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_wr_valid  <= 1'b0;
      reg_wr_offset <= '0;
      reg_wr_mirror <= 1'b0;
      reg_wr_data   <= '0;
      img_valid     <= 1'b0;
      img_data      <= '0;
      list_done     <= 1'b0;
    end else begin
      reg_wr_valid <= is_data;
      img_valid    <= is_img;
      list_done    <= done_now;
      if (is_data) begin
        reg_wr_offset <= slot_offset(cur_code);
        reg_wr_mirror <= cur_code[7];
        reg_wr_data   <= mem_rsp_data;
      end
      if (is_img) img_data <= mem_rsp_data;
    end
  end

  assign eng_state = state;

  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_IDLE) |-> !mem_req);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |=> !list_done);
  a_r6_done_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |-> (state == ENG_IDLE));
  a_r9_img_from_sec: assert property (@(posedge clk) disable iff (!rst_n)
    img_valid |-> ($past(state) == ENG_SEC));
  a_r4_one_output_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_valid && img_valid));
endmodule

// File: tb/cmdlist_dma_bench.sv
`timescale 1ns/1ps
module cmdlist_dma_bench;
  logic        clk = 1'b0, rst_n = 1'b0, win_start = 1'b0, ld_valid = 1'b0, ld_sel = 1'b0;
  logic [31:0] ld_data = '0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_req, reg_wr_valid, reg_wr_mirror, img_valid, list_done;
  logic [31:0] mem_addr, reg_wr_data, img_data;
  logic [8:0]  reg_wr_offset;
  logic [1:0]  eng_state;

  cmdlist_dma u_cmdlist_dma (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .ld_valid(ld_valid),
    .ld_sel(ld_sel), .ld_data(ld_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .reg_wr_valid(reg_wr_valid), .reg_wr_offset(reg_wr_offset),
    .reg_wr_mirror(reg_wr_mirror), .reg_wr_data(reg_wr_data),
    .img_valid(img_valid), .img_data(img_data), .list_done(list_done),
    .eng_state(eng_state));

  always #4 clk = ~clk;

  logic [31:0] mem [0:1023];
  logic [43:0] expq [$];
  int errors = 0, checks = 0, nreads = 0, wait_cnt = 0, lat = 0, done_cnt = 0, cycles = 0;
  bit saw_sec = 0, pend = 0;
  logic [31:0] held = '0, max_addr = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp(input logic [43:0] got, input string req);
    logic [43:0] e;
    if (expq.size() == 0) chk(1'b0, {req, " unexpected output"}, 64'(got), 64'h0);
    else begin
      e = expq.pop_front();
      chk(got == e, req, 64'(got), 64'(e));
    end
  endtask

  task automatic push_wr(input logic [8:0] off, input logic m, input logic [31:0] d);
    expq.push_back({2'd1, off, m, d});
  endtask
  task automatic push_img(input logic [31:0] d);
    expq.push_back({2'd2, 9'd0, 1'b0, d});
  endtask
  task automatic push_done();
    expq.push_back({2'd3, 42'd0});
  endtask
  task automatic mw(input logic [31:0] a, input logic [31:0] d);
    mem[a[11:2]] = d;
  endtask

  // Memory model: variable latency, checks that a waiting request is held (R12).
  always @(negedge clk) begin
    if (mem_rsp_valid) begin
      mem_rsp_valid = 1'b0;
      pend = 1'b0;
    end else if (pend) begin
      chk(mem_req && (mem_addr == held), "R12 request held", 64'(mem_addr), 64'(held));
    end
    if (rst_n && mem_req) begin
      if (wait_cnt >= lat) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mem[mem_addr[11:2]];
        nreads++;
        if (mem_addr > max_addr) max_addr = mem_addr;
        wait_cnt = 0;
        lat = (lat + 1) % 3;
        pend = 1'b0;
      end else begin
        wait_cnt++;
        pend = 1'b1;
        held = mem_addr;
      end
    end
  end

  // Monitor: pops the scoreboard as results appear.
  always @(negedge clk) begin
    if (eng_state == 2'd2) saw_sec = 1'b1;
    if (reg_wr_valid) cmp({2'd1, reg_wr_offset, reg_wr_mirror, reg_wr_data}, "R4 register write");
    if (img_valid) cmp({2'd2, 9'd0, 1'b0, img_data}, "R9 image word");
    if (list_done) begin
      done_cnt++;
      cmp({2'd3, 42'd0}, "R6 end pulse");
    end
  end

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic start(input logic [31:0] a, input logic [31:0] e);
    nreads = 0; done_cnt = 0; saw_sec = 0; max_addr = '0;
    @(negedge clk);
    win_start = 1'b1; ld_valid = 1'b1; ld_sel = 1'b0; ld_data = a;
    @(negedge clk);
    win_start = 1'b0; ld_sel = 1'b1; ld_data = e;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (done_cnt == 0 && n < 5000) begin
      @(posedge clk);
      n++;
    end
    repeat (3) settle();
    chk(done_cnt == 1, req, 64'(done_cnt), 64'd1);
    chk(expq.size() == 0, req, 64'(expq.size()), 64'd0);
    chk(eng_state == 2'd0, req, 64'(eng_state), 64'd0);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    chk(1'b0, "watchdog", 64'(cycles), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    chk(eng_state == 2'd0, "R1 state", 64'(eng_state), 64'd0);
    chk(!mem_req && !reg_wr_valid && !img_valid && !list_done, "R1 outputs",
        64'({mem_req, reg_wr_valid, img_valid, list_done}), 64'd0);

    // R3/R4: two groups, masked mode bits, mirror bit, pad code read before end.
    mw(32'h100, 32'h107F8504);
    mw(32'h104, 32'hA0000001); mw(32'h108, 32'hA0000002);
    mw(32'h10C, 32'hA0000003); mw(32'h110, 32'hA0000004);
    mw(32'h114, 32'h00001506);
    mw(32'h118, 32'hA0000005); mw(32'h11C, 32'hA0000006);
    push_wr(9'h010, 1'b0, 32'hA0000001); push_wr(9'h014, 1'b1, 32'hA0000002);
    push_wr(9'h1FC, 1'b0, 32'hA0000003); push_wr(9'h040, 1'b0, 32'hA0000004);
    push_wr(9'h018, 1'b0, 32'hA0000005); push_wr(9'h054, 1'b0, 32'hA0000006);
    push_done();
    start(32'h0000_0103, 32'h0000_0122);
    settle();
    chk(eng_state == 2'd1, "R2 end load starts primary", 64'(eng_state), 64'd1);
    // R2: a load during the walk is ignored.
    @(negedge clk); ld_valid = 1'b1; ld_sel = 1'b1; ld_data = 32'h0000_0FFC;
    @(negedge clk); ld_valid = 1'b0;
    wait_done("R3 primary walk");
    chk(nreads == 8, "R2 busy load ignored, R3 read count", 64'(nreads), 64'd8);

    // R5: last word is a header of pad codes.
    mw(32'h200, 32'h15151515);
    push_done();
    start(32'h200, 32'h204);
    wait_done("R5 pad at end");
    chk(nreads == 1, "R5 no read past end", 64'(nreads), 64'd1);
    chk(max_addr == 32'h200, "R5 highest address", 64'(max_addr), 64'h200);

    // R6: start beyond end makes no read.
    push_done();
    start(32'h300, 32'h2F0);
    wait_done("R6 start past end");
    chk(nreads == 0, "R6 no read", 64'(nreads), 64'd0);

    // R7/R8/R10: register-mode secondary, then resume primary with a fresh header.
    mw(32'h400, 32'h06053130); mw(32'h404, 32'h00000600); mw(32'h408, 32'h0000060C);
    mw(32'h40C, 32'h0000000A); mw(32'h410, 32'hC0000005);
    mw(32'h600, 32'h00008908); mw(32'h604, 32'hC0000001); mw(32'h608, 32'hC0000002);
    push_wr(9'h0C0, 1'b0, 32'h600); push_wr(9'h0C4, 1'b0, 32'h60C);
    push_wr(9'h020, 1'b0, 32'hC0000001); push_wr(9'h024, 1'b1, 32'hC0000002);
    push_wr(9'h028, 1'b0, 32'hC0000005);
    push_done();
    start(32'h400, 32'h414);
    wait_done("R10 return to primary");
    chk(saw_sec, "R7 secondary entered", 64'(saw_sec), 64'd1);
    chk(nreads == 8, "R8 read count", 64'(nreads), 64'd8);

    // R9/R10: image-mode secondary; switch coincides with primary end.
    mw(32'h500, 32'h00003130); mw(32'h504, 32'h00000701); mw(32'h508, 32'h0000070C);
    mw(32'h700, 32'hD0000001); mw(32'h704, 32'hD0000002); mw(32'h708, 32'hD0000003);
    push_wr(9'h0C0, 1'b0, 32'h701); push_wr(9'h0C4, 1'b0, 32'h70C);
    push_img(32'hD0000001); push_img(32'hD0000002); push_img(32'hD0000003);
    push_done();
    start(32'h500, 32'h50C);
    wait_done("R9 image stream");
    chk(nreads == 6, "R10 idle after both lists", 64'(nreads), 64'd6);

    // R11: 300-word list stalls at 280 until a window grant.
    for (int g = 0; g < 60; g++) begin
      mw(32'h800 + 32'(g * 20), 32'h04030201);
      for (int k = 0; k < 4; k++) begin
        mw(32'h800 + 32'(g * 20 + 4 + k * 4), 32'hB0000000 + 32'(g * 4 + k));
        push_wr(9'(4 * (k + 1)), 1'b0, 32'hB0000000 + 32'(g * 4 + k));
      end
    end
    push_done();
    start(32'h800, 32'h800 + 32'd1200);
    repeat (1500) @(posedge clk);
    settle();
    chk(nreads == 280, "R11 budget cap", 64'(nreads), 64'd280);
    chk(eng_state == 2'd1, "R11 still primary", 64'(eng_state), 64'd1);
    @(negedge clk); win_start = 1'b1;
    @(negedge clk); win_start = 1'b0;
    wait_done("R11 resume after grant");
    chk(nreads == 300, "R11 total reads", 64'(nreads), 64'd300);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule